// File: doc/BRIEF.md
# Arbitrated Dual-Port Mailbox Memory

This block is a 2048-location, byte-wide shared memory through which a host processor and a small microcontroller exchange messages. Each side has its own port with address, write data, read data, chip select and separate read and write strobes. Both ports work at full rate as long as they touch different locations. When both select the same location, an arbiter inside the block gives the location to the port whose access started first. The other port is told that it was refused.

The two sides learn about a refusal in different ways, and neither side is ever stalled. The microcontroller has a latched status bit, `m_ok`, which records whether its most recent access went through or collided. Firmware reads this bit after each access and repeats the access when it is 0. The host reads a status register through its I/O space. A single decoded I/O address enables a driver on data bit 0, and that bit shows whether the host's current memory access is being refused.

Read data on both ports comes out of a register. It appears one clock after the cycle that presented the read.

Top module: `dpm_mailbox`

## Requirements
- R1: Either port can write any of the 2048 byte locations. A read presented in cycle n returns the stored byte on that port's read-data output from the edge that ends cycle n. In the same cycle, the host may access location X while the microcontroller accesses location Y, with X different from Y.
- R2: When the two ports access different locations in the same cycle, both accesses complete. Neither port is marked busy.
- R3: An access is active while chip select is high together with a read or write strobe. It counts as a new access in a cycle where it was not active in the previous cycle, or where its address changed. When both ports are active on the same location, the port whose access started in an earlier cycle wins, and the other port loses. The winner keeps the location for as long as both accesses stay unchanged.
- R4: When both ports start a new access to the same location in the same cycle, the host port wins.
- R5: A write from the losing port leaves the stored byte unchanged. A read from the losing port still returns the stored byte.
- R6: `m_ok` is updated only in the first cycle of each new microcontroller access, and holds its value at all other times. It becomes 1 if that cycle had no conflict and 0 if the microcontroller lost. The microcontroller's accesses are never stalled.
- R7: `h_stat_oe` is 1 exactly when `h_io_rd` is 1 and bits 9..5 of `h_io_addr` equal 11001 (for example address 0x330). Bits 4..0 of the address are ignored. While `h_stat_oe` is 1, `h_stat_d0` is 0 if the host's current memory access is losing and 1 otherwise.
- R8: After reset, `m_ok` is 1 and both read-data outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| h_cs | input | 1 | Host memory chip select |
| h_rd | input | 1 | Host read strobe |
| h_wr | input | 1 | Host write strobe |
| h_addr | input | 11 | Host memory address |
| h_wdata | input | 8 | Host write data |
| h_rdata | output | 8 | Host read data (registered) |
| h_io_rd | input | 1 | Host I/O read strobe |
| h_io_addr | input | 10 | Host I/O address |
| h_stat_d0 | output | 1 | Host status data bit 0, valid while enabled |
| h_stat_oe | output | 1 | Enable of the bit-0 status driver |
| m_cs | input | 1 | Microcontroller chip select |
| m_rd | input | 1 | Microcontroller read strobe |
| m_wr | input | 1 | Microcontroller write strobe |
| m_addr | input | 11 | Microcontroller address |
| m_wdata | input | 8 | Microcontroller write data |
| m_rdata | output | 8 | Microcontroller read data (registered) |
| m_ok | output | 1 | Latched result of the last microcontroller access (1 = no conflict) |

## Verification
The bench aims at arrival order and works through three cases:
- **Both ports start on the same cycle.** A design without the host-first rule would let the microcontroller's byte land in memory.
- **The microcontroller holds a location and the host joins later.** A design that ignores hold time would steal the location from the microcontroller and corrupt it.
- **The host holds a location and the microcontroller joins later.** The microcontroller's write must be dropped, and a read that loses must still return the stored byte.

The status latch is watched across idle cycles and across host-only traffic. A latch that follows every cycle, rather than only the start of each access, would lose the 0 before the firmware reads it.

All 1024 I/O addresses are swept. Any decode that looks at more or fewer than bits 9..5 would enable the status driver at the wrong place.

Every location is written with disjoint-address traffic from both ports at once, then read back crosswise. This catches false busy on different addresses and any port that writes the wrong location.

// File: rtl/dpm_pkg.sv
package dpm_pkg;
    localparam int unsigned DPM_AW   = 11;
    localparam int unsigned DPM_DW   = 8;
    localparam int unsigned DPM_IOAW = 10;
    // I/O location of the host status register; only bits 9..5 are decoded
    localparam logic [DPM_IOAW-1:0] DPM_STAT_IO = 10'h330;
endpackage

// File: rtl/dpm_arbiter.sv
module dpm_arbiter #(
    parameter int unsigned AW = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          l_act,
    input  logic          r_act,
    input  logic [AW-1:0] l_addr,
    input  logic [AW-1:0] r_addr,
    output logic          l_lose,
    output logic          r_lose,
    output logic          r_new
);
    typedef struct packed {
        logic          l_act;
        logic          r_act;
        logic [AW-1:0] l_addr;
        logic [AW-1:0] r_addr;
        logic          win_r;
    } arb_t;

    arb_t st_d, st_q;
    logic l_held, r_held, clash, right_wins;

    always_comb begin
        l_held = st_q.l_act && (st_q.l_addr == l_addr);
        r_held = st_q.r_act && (st_q.r_addr == r_addr);
        clash  = l_act && r_act && (l_addr == r_addr);
        if (l_held && !r_held)      right_wins = 1'b0;
        else if (r_held && !l_held) right_wins = 1'b1;
        else if (l_held && r_held)  right_wins = st_q.win_r;
        else                        right_wins = 1'b0;   // same-cycle tie: host
        l_lose = clash && right_wins;
        r_lose = clash && !right_wins;
        r_new  = r_act && !r_held;
        st_d.l_act  = l_act;
        st_d.r_act  = r_act;
        st_d.l_addr = l_addr;
        st_d.r_addr = r_addr;
        st_d.win_r  = clash ? right_wins : st_q.win_r;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_DIFF_ADDR_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        (l_addr != r_addr) |-> (!l_lose && !r_lose)); // R2
    AST_SINGLE_LOSER: assert property (@(posedge clk) disable iff (!rst_n)
        !(l_lose && r_lose)); // R3
    AST_WINNER_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        l_lose |=> (!(l_act && r_act && $stable(l_addr) && $stable(r_addr)) || l_lose)); // R3
    AST_TIE_HOST: assert property (@(posedge clk) disable iff (!rst_n)
        (l_act && r_act && l_addr == r_addr && !st_q.l_act && !st_q.r_act) |-> r_lose); // R4
endmodule

// File: rtl/dpm_store.sv
module dpm_store #(
    parameter int unsigned AW = 11,
    parameter int unsigned DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          l_we,
    input  logic          l_re,
    input  logic [AW-1:0] l_addr,
    input  logic [DW-1:0] l_wdata,
    output logic [DW-1:0] l_rdata,
    input  logic          r_we,
    input  logic          r_re,
    input  logic [AW-1:0] r_addr,
    input  logic [DW-1:0] r_wdata,
    output logic [DW-1:0] r_rdata
);
    localparam int unsigned DEPTH = 1 << AW;

    typedef struct packed {
        logic [DW-1:0] l;
        logic [DW-1:0] r;
    } rd_t;

    logic [DW-1:0] mem [DEPTH];
    rd_t rd_d, rd_q;

    always_comb begin
        rd_d = rd_q;
        if (l_re) rd_d.l = mem[l_addr];
        if (r_re) rd_d.r = mem[r_addr];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= rd_d;
    end

    always_ff @(posedge clk) begin
        if (l_we) mem[l_addr] <= l_wdata;
        if (r_we) mem[r_addr] <= r_wdata;
    end

    assign l_rdata = rd_q.l;
    assign r_rdata = rd_q.r;

    AST_NO_DUAL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !(l_we && r_we && l_addr == r_addr)); // R5
endmodule

// File: rtl/dpm_host_stat.sv
module dpm_host_stat #(
    parameter int unsigned   IOAW    = 10,
    parameter logic [IOAW-1:0] STAT_IO = 10'h330
) (
    input  logic            io_rd,
    input  logic [IOAW-1:0] io_addr,
    input  logic            host_lose,
    output logic            stat_d0,
    output logic            stat_oe
);
    logic sel;
    always_comb begin
        sel     = io_rd && (io_addr[IOAW-1:5] == STAT_IO[IOAW-1:5]);
        stat_oe = sel;
        stat_d0 = sel ? !host_lose : 1'b0;
    end
endmodule

// File: rtl/dpm_mailbox.sv
module dpm_mailbox
    import dpm_pkg::*;
#(
    parameter int unsigned AW   = DPM_AW,
    parameter int unsigned DW   = DPM_DW,
    parameter int unsigned IOAW = DPM_IOAW
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            h_cs,
    input  logic            h_rd,
    input  logic            h_wr,
    input  logic [AW-1:0]   h_addr,
    input  logic [DW-1:0]   h_wdata,
    output logic [DW-1:0]   h_rdata,
    input  logic            h_io_rd,
    input  logic [IOAW-1:0] h_io_addr,
    output logic            h_stat_d0,
    output logic            h_stat_oe,
    input  logic            m_cs,
    input  logic            m_rd,
    input  logic            m_wr,
    input  logic [AW-1:0]   m_addr,
    input  logic [DW-1:0]   m_wdata,
    output logic [DW-1:0]   m_rdata,
    output logic            m_ok
);
    logic h_act, m_act, h_lose, m_lose, m_new;
    logic ok_d, ok_q;

    assign h_act = h_cs && (h_rd || h_wr);
    assign m_act = m_cs && (m_rd || m_wr);

    dpm_arbiter #(.AW(AW)) u_arb (
        .clk(clk), .rst_n(rst_n),
        .l_act(h_act), .r_act(m_act),
        .l_addr(h_addr), .r_addr(m_addr),
        .l_lose(h_lose), .r_lose(m_lose), .r_new(m_new)
    );

    dpm_store #(.AW(AW), .DW(DW)) u_store (
        .clk(clk), .rst_n(rst_n),
        .l_we(h_cs && h_wr && !h_lose), .l_re(h_cs && h_rd),
        .l_addr(h_addr), .l_wdata(h_wdata), .l_rdata(h_rdata),
        .r_we(m_cs && m_wr && !m_lose), .r_re(m_cs && m_rd),
        .r_addr(m_addr), .r_wdata(m_wdata), .r_rdata(m_rdata)
    );

    dpm_host_stat #(.IOAW(IOAW), .STAT_IO(DPM_STAT_IO)) u_stat (
        .io_rd(h_io_rd), .io_addr(h_io_addr), .host_lose(h_lose),
        .stat_d0(h_stat_d0), .stat_oe(h_stat_oe)
    );

    always_comb begin
        ok_d = ok_q;
        if (m_new) ok_d = !m_lose;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ok_q <= 1'b1;
        else        ok_q <= ok_d;
    end

    assign m_ok = ok_q;

    AST_OK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !m_new |=> $stable(m_ok)); // R6
    AST_OK_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        m_new |=> (m_ok == !$past(m_lose))); // R6
endmodule

// File: tb/dpm_mailbox_bench.sv
`timescale 1ns/1ps
module dpm_mailbox_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic h_cs = 0, h_rd = 0, h_wr = 0, h_io_rd = 0;
    logic [10:0] h_addr = '0;
    logic [7:0]  h_wdata = '0;
    logic [9:0]  h_io_addr = '0;
    logic m_cs = 0, m_rd = 0, m_wr = 0;
    logic [10:0] m_addr = '0;
    logic [7:0]  m_wdata = '0;
    logic [7:0]  h_rdata, m_rdata;
    logic h_stat_d0, h_stat_oe, m_ok;

    logic [7:0] ref_mem [2048];
    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #10 clk = ~clk;   // 50 MHz

    dpm_mailbox u_dpm_mailbox (
        .clk(clk), .rst_n(rst_n),
        .h_cs(h_cs), .h_rd(h_rd), .h_wr(h_wr), .h_addr(h_addr),
        .h_wdata(h_wdata), .h_rdata(h_rdata),
        .h_io_rd(h_io_rd), .h_io_addr(h_io_addr),
        .h_stat_d0(h_stat_d0), .h_stat_oe(h_stat_oe),
        .m_cs(m_cs), .m_rd(m_rd), .m_wr(m_wr), .m_addr(m_addr),
        .m_wdata(m_wdata), .m_rdata(m_rdata), .m_ok(m_ok)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick;
        @(posedge clk);
        #1;
    endtask

    task automatic idle_all;
        h_cs = 0; h_rd = 0; h_wr = 0; h_io_rd = 0;
        m_cs = 0; m_rd = 0; m_wr = 0;
    endtask

    task automatic host_acc(input bit wr, input logic [10:0] a, input logic [7:0] d);
        h_cs = 1; h_rd = !wr; h_wr = wr; h_addr = a; h_wdata = d;
    endtask

    task automatic mcu_acc(input bit wr, input logic [10:0] a, input logic [7:0] d);
        m_cs = 1; m_rd = !wr; m_wr = wr; m_addr = a; m_wdata = d;
    endtask

    task automatic finish_up;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual hung expected done");
            finish_up();
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R8 reset state
        check("R8 m_ok", m_ok, 1);
        check("R8 h_rdata", h_rdata, 0);
        check("R8 m_rdata", m_rdata, 0);
        check("R7 oe idle", h_stat_oe, 0);
        rst_n = 1;
        tick();

        // R1/R2: fill every location, both ports writing disjoint halves together
        for (int a = 0; a < 1024; a++) begin
            host_acc(1, 11'(a), 8'(a) ^ 8'h5A);
            mcu_acc(1, 11'(a + 1024), 8'(a * 3));
            h_io_rd = 1; h_io_addr = 10'h330;
            #1;
            check("R2 no busy on distinct addresses", h_stat_d0, 1);
            ref_mem[a] = 8'(a) ^ 8'h5A;
            ref_mem[a + 1024] = 8'(a * 3);
            tick();
            check("R2 mcu write accepted", m_ok, 1);
        end
        idle_all();
        tick();

        // R1: crosswise readback
        for (int a = 0; a < 1024; a++) begin
            host_acc(0, 11'(a + 1024), 8'h00);
            mcu_acc(0, 11'(a), 8'h00);
            tick();
            check("R1 host read", h_rdata, ref_mem[a + 1024]);
            check("R1 mcu read", m_rdata, ref_mem[a]);
        end
        idle_all();
        tick();

        // R4: same-cycle tie on location 5, host wins
        host_acc(1, 11'd5, 8'hAA);
        mcu_acc(1, 11'd5, 8'h55);
        h_io_rd = 1; h_io_addr = 10'h330;
        #1;
        check("R4 host not busy on tie", h_stat_d0, 1);
        tick();
        ref_mem[5] = 8'hAA;
        check("R4 mcu flagged on tie", m_ok, 0);
        idle_all();
        tick();
        host_acc(0, 11'd5, 8'h00);
        tick();
        check("R4 tie stores host byte", h_rdata, ref_mem[5]);
        idle_all();
        tick();

        // R3: mcu first on location 9, host joins later and loses
        mcu_acc(1, 11'd9, 8'h11);
        tick();
        ref_mem[9] = 8'h11;
        check("R3 mcu alone ok", m_ok, 1);
        host_acc(1, 11'd9, 8'h22);
        h_io_rd = 1; h_io_addr = 10'h330;
        #1;
        check("R7 host busy while mcu holds", h_stat_d0, 0);
        check("R7 status enabled", h_stat_oe, 1);
        tick();
        check("R3 mcu holder keeps ok", m_ok, 1);
        #1;
        check("R3 host still losing", h_stat_d0, 0);
        idle_all();
        tick();
        host_acc(0, 11'd9, 8'h00);
        tick();
        check("R5 losing host write dropped", h_rdata, ref_mem[9]);

        // R3/R5: host holds location 9, mcu joins and loses its write
        mcu_acc(1, 11'd9, 8'h33);
        h_io_rd = 1; h_io_addr = 10'h330;
        #1;
        check("R3 host holder not busy", h_stat_d0, 1);
        tick();
        check("R3 late mcu loses", m_ok, 0);
        m_cs = 0; m_rd = 0; m_wr = 0;
        tick();
        check("R6 hold after idle", m_ok, 0);
        mcu_acc(0, 11'd9, 8'h00);
        tick();
        check("R5 losing read returns data", m_rdata, ref_mem[9]);
        check("R5 losing read flagged", m_ok, 0);
        m_cs = 0; m_rd = 0;
        // R6: host-only traffic and idle cycles must not touch the latch
        for (int k = 0; k < 4; k++) begin
            host_acc(k[0], 11'(k + 20), 8'(k));
            if (k[0]) ref_mem[k + 20] = 8'(k);
            tick();
            check("R6 latch holds 0", m_ok, 0);
        end
        idle_all();
        tick();
        check("R6 latch holds 0 idle", m_ok, 0);
        mcu_acc(1, 11'd9, 8'h33);
        tick();
        ref_mem[9] = 8'h33;
        check("R6 retry succeeds", m_ok, 1);
        mcu_acc(0, 11'd9, 8'h00);
        tick();
        check("R1 retry stored", m_rdata, ref_mem[9]);
        idle_all();
        tick();

        // R7: sweep the whole I/O space
        for (int io = 0; io < 1024; io++) begin
            h_io_rd = 1; h_io_addr = 10'(io);
            #1;
            check("R7 decode", h_stat_oe, ((io >> 5) == 25) ? 1 : 0);
            #1;
        end
        h_io_rd = 0; h_io_addr = 10'h330;
        #1;
        check("R7 no strobe no drive", h_stat_oe, 0);
        tick();

        done = 1;
        finish_up();
    end
endmodule